// File: doc/BRIEF.md
# Fixed Off-Time H-Bridge Chopper Controller

This block is the digital sequencer for one winding of a bipolar stepper motor that is driven through a full H-bridge. It drives four gate enables: a high-side source and a low-side sink on each of the two bridge legs, A and B. While driving, it turns on one diagonal of the bridge, chosen by a direction bit. When an external current comparator reports that the winding current has reached its set level, the block starts a chopping off-time. That off-time lasts a fixed number of clock cycles, and the selected decay style decides which transistors stay on while the current recirculates. When the off-time ends, the drive diagonal is turned back on.

Every time a diagonal is about to turn on after the bridge has been released or reversed, the block first holds all four gates off for a programmable dead time. This rule covers start-up and any change of the direction bit. A 3-bit current-level code is registered and handed to the external reference converter. A level code of zero parks the bridge with every gate off.

The off-time, dead time and the fast-decay share of a mixed-decay off-time are parameters counted in clock cycles. A single interval counter times all of them.

Top module: `hbridge_chopper`

## Requirements
- R1: After reset all four gate outputs are 0 and `level_o` is 0. They stay 0 while `level_i` is 3'b000.
- R2: In the drive phase, `dir_i`=0 enables `src_a_o` and `snk_b_o` only, and `dir_i`=1 enables `src_b_o` and `snk_a_o` only.
- R3: `trip_i` high in the drive phase starts the off-time on the next cycle, and both sources are off from that cycle. `trip_i` is ignored during the off-time, the dead time and idle.
- R4: The decay codes 2'b00 and 2'b11 select slow decay. During the whole off-time only the sink of the drive diagonal stays on (`snk_b_o` for `dir_i`=0, `snk_a_o` for `dir_i`=1).
- R5: The decay code 2'b01 selects fast decay. All four gates are off for the whole off-time.
- R6: The decay code 2'b10 selects mixed decay. All four gates are off for the first MIX_FAST_CYCLES cycles of the off-time, and then only the drive-diagonal sink is on for the rest of it.
- R7: The off-time lasts exactly OFF_CYCLES cycles. After it the drive diagonal is enabled again.
- R8: A change of `dir_i` during drive, off-time or dead time holds all gates off from the next cycle for DEAD_CYCLES cycles, and the count restarts at each change. The diagonal for the new direction then turns on. Leaving idle also passes through this dead time.
- R9: `level_i`=3'b000 turns all gates off from the next cycle, whatever `dir_i`, `trip_i` and `decay_i` do.
- R10: The source and the sink of the same leg are never on together.
- R11: `level_o` equals `level_i` delayed by one clock cycle.
- R12: The decay code is captured when the trip is taken. Changes of `decay_i` during the off-time have no effect on that off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Winding current direction |
| level_i | input | 3 | Current-level code; 0 disables the bridge |
| trip_i | input | 1 | Synchronous current-trip from the sense comparator |
| decay_i | input | 2 | Decay select: 00/11 slow, 01 fast, 10 mixed |
| level_o | output | 3 | Registered level code for the reference converter |
| src_a_o | output | 1 | High-side enable, leg A |
| snk_a_o | output | 1 | Low-side enable, leg A |
| src_b_o | output | 1 | High-side enable, leg B |
| snk_b_o | output | 1 | Low-side enable, leg B |

## Verification
The embedded assertions check these properties on every cycle:
- leg exclusivity;
- bridge shutdown one cycle after a zero level code or a direction change;
- source release after a taken trip;
- the bounds of the interval counter in the off-time and dead-time states;
- the decay code holding steady through an off-time;
- the one-cycle delay of the level output.

The exact lengths of the intervals can only be shown by the directed scenarios. These cover the per-cycle gate profile of each decay style, the mixed-decay switchover cycle, a trip ignored inside an off-time, and a restarted dead time after a reversal in mid-chop.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEAD  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_OFF   = 2'd3
    } chop_state_e;

    typedef enum logic [1:0] {
        DK_SLOW     = 2'b00,
        DK_FAST     = 2'b01,
        DK_MIXED    = 2'b10,
        DK_SLOW_ALT = 2'b11
    } decay_e;

    typedef struct packed {
        logic src_a;
        logic snk_a;
        logic src_b;
        logic snk_b;
    } gate_t;

    localparam gate_t GATES_OFF = '{src_a: 1'b0, snk_a: 1'b0, src_b: 1'b0, snk_b: 1'b0};

    function automatic decay_e normalise_decay(input logic [1:0] code);
        decay_e m;
        m = decay_e'(code);
        if (m == DK_SLOW_ALT) begin
            m = DK_SLOW;
        end
        return m;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_reg_t;

    timer_reg_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != CNT_MAX) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt_o = tmr_q.cnt;

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_CYCLES  = 100,
    parameter int DEAD_CYCLES = 50,
    parameter int CNT_W       = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             level_nz_i,
    input  logic             dir_i,
    input  logic             trip_i,
    input  logic [1:0]       decay_i,
    input  logic [CNT_W-1:0] cnt_i,
    output chop_state_e      state_o,
    output logic             dir_o,
    output decay_e           mode_o,
    output logic             restart_o
);

    localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_CYCLES - 1);
    localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYCLES - 1);

    typedef struct packed {
        chop_state_e state;
        logic        dir;
        decay_e      mode;
    } fsm_reg_t;

    fsm_reg_t fsm_d, fsm_q;
    logic     restart;
    logic     dir_flip;

    assign dir_flip = (dir_i != fsm_q.dir);

    always_comb begin
        fsm_d   = fsm_q;
        restart = 1'b0;
        if (!level_nz_i) begin
            fsm_d.state = ST_IDLE;
        end else begin
            unique case (fsm_q.state)
                ST_IDLE: begin
                    fsm_d.state = ST_DEAD;
                    fsm_d.dir   = dir_i;
                    restart     = 1'b1;
                end
                ST_DEAD: begin
                    if (dir_flip) begin
                        fsm_d.dir = dir_i;
                        restart   = 1'b1;
                    end else if (cnt_i == DEAD_LAST) begin
                        fsm_d.state = ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    if (dir_flip) begin
                        fsm_d.state = ST_DEAD;
                        fsm_d.dir   = dir_i;
                        restart     = 1'b1;
                    end else if (trip_i) begin
                        fsm_d.state = ST_OFF;
                        fsm_d.mode  = normalise_decay(decay_i);
                        restart     = 1'b1;
                    end
                end
                ST_OFF: begin
                    if (dir_flip) begin
                        fsm_d.state = ST_DEAD;
                        fsm_d.dir   = dir_i;
                        restart     = 1'b1;
                    end else if (cnt_i == OFF_LAST) begin
                        fsm_d.state = ST_DRIVE;
                    end
                end
                default: fsm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: ST_IDLE, dir: 1'b0, mode: DK_SLOW};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o   = fsm_q.state;
    assign dir_o     = fsm_q.dir;
    assign mode_o    = fsm_q.mode;
    assign restart_o = restart;

    // R7: off-time never outlasts its programmed length
    assert_off_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state == ST_OFF) |-> (cnt_i < CNT_W'(OFF_CYCLES)));

    // R8: dead time never outlasts its programmed length
    assert_dead_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state == ST_DEAD) |-> (cnt_i < CNT_W'(DEAD_CYCLES)));

    // R7: drive resumes from off-time only on its final count
    assert_off_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state == ST_OFF && level_nz_i && !dir_flip && cnt_i != OFF_LAST)
        |=> (fsm_q.state == ST_OFF));

    // R12: captured decay style stays fixed while in off-time
    assert_mode_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state == ST_OFF) |=> $stable(fsm_q.mode) || (fsm_q.state != ST_OFF));

    // R3: trip outside drive never opens an off-time
    assert_trip_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.state != ST_DRIVE && fsm_q.state != ST_OFF) |=> (fsm_q.state != ST_OFF));

endmodule

// File: rtl/chop_gate_decode.sv
module chop_gate_decode
    import chop_pkg::*;
#(
    parameter int CNT_W           = 8,
    parameter int MIX_FAST_CYCLES = 30
) (
    input  chop_state_e      state_i,
    input  logic             dir_i,
    input  decay_e           mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    output gate_t            gates_o
);

    localparam logic [CNT_W-1:0] MIX_SPLIT = CNT_W'(MIX_FAST_CYCLES);

    gate_t drive_pair;
    gate_t hold_sink;
    logic  sink_kept;

    always_comb begin
        drive_pair = GATES_OFF;
        hold_sink  = GATES_OFF;
        if (dir_i) begin
            drive_pair.src_b = 1'b1;
            drive_pair.snk_a = 1'b1;
            hold_sink.snk_a  = 1'b1;
        end else begin
            drive_pair.src_a = 1'b1;
            drive_pair.snk_b = 1'b1;
            hold_sink.snk_b  = 1'b1;
        end
    end

    always_comb begin
        unique case (mode_i)
            DK_FAST:  sink_kept = 1'b0;
            DK_MIXED: sink_kept = (cnt_i >= MIX_SPLIT);
            default:  sink_kept = 1'b1;
        endcase
    end

    always_comb begin
        unique case (state_i)
            ST_DRIVE: gates_o = drive_pair;
            ST_OFF:   gates_o = sink_kept ? hold_sink : GATES_OFF;
            default:  gates_o = GATES_OFF;
        endcase
    end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
    import chop_pkg::*;
#(
    parameter int LEVEL_W         = 3,
    parameter int OFF_CYCLES      = 100,
    parameter int DEAD_CYCLES     = 50,
    parameter int MIX_FAST_CYCLES = 30
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               dir_i,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic               trip_i,
    input  logic [1:0]         decay_i,
    output logic [LEVEL_W-1:0] level_o,
    output logic               src_a_o,
    output logic               snk_a_o,
    output logic               src_b_o,
    output logic               snk_b_o
);

    localparam int MAX_SPAN = (OFF_CYCLES > DEAD_CYCLES) ? OFF_CYCLES : DEAD_CYCLES;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    typedef struct packed {
        logic [LEVEL_W-1:0] level;
    } top_reg_t;

    top_reg_t top_d, top_q;

    chop_state_e      state;
    logic             dir_cur;
    decay_e           mode_cur;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    gate_t            gates;
    logic             level_nz;

    assign level_nz = |level_i;

    chop_timer #(.CNT_W(CNT_W)) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .cnt_o     (cnt)
    );

    chop_fsm #(
        .OFF_CYCLES  (OFF_CYCLES),
        .DEAD_CYCLES (DEAD_CYCLES),
        .CNT_W       (CNT_W)
    ) i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .level_nz_i (level_nz),
        .dir_i      (dir_i),
        .trip_i     (trip_i),
        .decay_i    (decay_i),
        .cnt_i      (cnt),
        .state_o    (state),
        .dir_o      (dir_cur),
        .mode_o     (mode_cur),
        .restart_o  (restart)
    );

    chop_gate_decode #(
        .CNT_W           (CNT_W),
        .MIX_FAST_CYCLES (MIX_FAST_CYCLES)
    ) i_decode (
        .state_i (state),
        .dir_i   (dir_cur),
        .mode_i  (mode_cur),
        .cnt_i   (cnt),
        .gates_o (gates)
    );

    always_comb begin
        top_d       = top_q;
        top_d.level = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign level_o = top_q.level;
    assign src_a_o = gates.src_a;
    assign snk_a_o = gates.snk_a;
    assign src_b_o = gates.src_b;
    assign snk_b_o = gates.snk_b;

    // R10: no shoot-through on either leg
    assert_leg_a_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(src_a_o && snk_a_o));
    assert_leg_b_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(src_b_o && snk_b_o));

    // R9: zero level code parks the bridge on the next cycle
    assert_zero_level_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i == '0) |=> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

    // R8: a direction change blanks the bridge on the next cycle
    assert_dir_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state != ST_IDLE && dir_i != dir_cur) |=> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

    // R3: a trip taken in drive releases both sources
    assert_trip_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_DRIVE && trip_i && level_nz && dir_i == dir_cur) |=> !(src_a_o || src_b_o));

    // R5: fast decay leaves the whole bridge off during the off-time
    assert_fast_all_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_OFF && mode_cur == DK_FAST) |-> !(src_a_o || snk_a_o || src_b_o || snk_b_o));

    // R11: level code is delayed by exactly one cycle
    assert_level_delay_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (level_o == $past(level_i)));

endmodule

// File: tb/test_hbridge_chopper.sv
module test_hbridge_chopper;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_C      = 12;
    localparam int DEAD_C     = 6;
    localparam int MIX_C      = 4;

    localparam logic [3:0] G_OFF   = 4'b0000;  // {src_a, snk_a, src_b, snk_b}
    localparam logic [3:0] G_DRV0  = 4'b1001;
    localparam logic [3:0] G_DRV1  = 4'b0110;
    localparam logic [3:0] G_SINK0 = 4'b0001;
    localparam logic [3:0] G_SINK1 = 4'b0100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir = 1'b0;
    logic [2:0] level = 3'd0;
    logic       trip = 1'b0;
    logic [1:0] decay = 2'b00;
    logic [2:0] level_out;
    logic       src_a, snk_a, src_b, snk_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbridge_chopper #(
        .LEVEL_W         (3),
        .OFF_CYCLES      (OFF_C),
        .DEAD_CYCLES     (DEAD_C),
        .MIX_FAST_CYCLES (MIX_C)
    ) i_hbridge_chopper (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .dir_i   (dir),
        .level_i (level),
        .trip_i  (trip),
        .decay_i (decay),
        .level_o (level_out),
        .src_a_o (src_a),
        .snk_a_o (snk_a),
        .src_b_o (src_b),
        .snk_b_o (snk_b)
    );

    task automatic chk_gates(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {src_a, snk_a, src_b, snk_b};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s gates act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_level(input logic [2:0] exp, input string tag);
        n_checks++;
        if (level_out !== exp) begin
            n_fail++;
            $display("FAIL %s level_o act=%0d exp=%0d", tag, level_out, exp);
        end
    endtask

    function automatic logic [3:0] drv(input logic d);
        return d ? G_DRV1 : G_DRV0;
    endfunction

    function automatic logic [3:0] snk(input logic d);
        return d ? G_SINK1 : G_SINK0;
    endfunction

    // Dead time just requested at this negedge: expect DEAD_C off cycles, then drive
    task automatic run_blank(input logic d, input string tag);
        for (int n = 1; n <= DEAD_C; n++) begin
            @(negedge clk);
            chk_gates(G_OFF, tag);
        end
        @(negedge clk);
        chk_gates(drv(d), {tag, " R2 diagonal"});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_gates(G_OFF, "R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_gates(G_OFF, "R1 idle with zero level");
        chk_level(3'd0, "R1 level after reset");
    endtask

    task automatic t_startup(input logic d);
        dir = d;
        level = 3'd3;
        run_blank(d, "R8 start-up dead time");
    endtask

    // In drive at entry. ign: pulse trip mid off-time; chg: change decay mid off-time
    task automatic t_chop(input logic [1:0] mode, input bit ign, input bit chg, input string tag);
        logic [3:0] exp;
        decay = mode;
        trip  = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        for (int n = 1; n <= OFF_C; n++) begin
            case (mode)
                2'b01:   exp = G_OFF;
                2'b10:   exp = (n <= MIX_C) ? G_OFF : snk(dir);
                default: exp = snk(dir);
            endcase
            chk_gates(exp, tag);
            trip = (ign && n == 3);
            if (chg && n == 2) decay = 2'b01;
            @(negedge clk);
        end
        trip = 1'b0;
        chk_gates(drv(dir), "R7 drive resumes after off-time");
        @(negedge clk);
        chk_gates(drv(dir), "R7 drive holds without trip");
    endtask

    task automatic t_reverse();
        dir = ~dir;
        run_blank(dir, "R8 reversal in drive");
    endtask

    task automatic t_reverse_in_offtime();
        decay = 2'b00;
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        @(negedge clk);
        chk_gates(snk(dir), "R4 off-time before reversal");
        dir = ~dir;
        @(negedge clk);
        chk_gates(G_OFF, "R8 reversal in off-time");
        dir = ~dir;  // flip again during dead time: count restarts
        run_blank(dir, "R8 restarted dead time");
    endtask

    task automatic t_zero_level();
        level = 3'd0;
        @(negedge clk);
        chk_gates(G_OFF, "R9 zero level parks bridge");
        for (int n = 0; n < 3; n++) begin
            dir  = ~dir;
            trip = 1'b1;
            decay = 2'(n);
            @(negedge clk);
            chk_gates(G_OFF, "R9 inputs ignored at zero level");
        end
        trip = 1'b0;
        decay = 2'b00;
        level = 3'd2;
        run_blank(dir, "R8 leaving idle");
    endtask

    task automatic t_level_pass();
        level = 3'd5;
        @(negedge clk);
        chk_level(3'd5, "R11 level follows");
        chk_gates(drv(dir), "R11 level change keeps drive");
        level = 3'd7;
        @(negedge clk);
        chk_level(3'd7, "R11 level follows again");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_startup(1'b0);
        t_chop(2'b00, 1'b0, 1'b0, "R4 slow decay dir0");
        t_chop(2'b01, 1'b0, 1'b0, "R5 fast decay dir0");
        t_chop(2'b10, 1'b0, 1'b0, "R6 mixed decay dir0");
        t_chop(2'b00, 1'b1, 1'b0, "R3 trip ignored in off-time");
        t_chop(2'b00, 1'b0, 1'b1, "R12 decay change ignored");
        t_reverse();
        t_chop(2'b11, 1'b0, 1'b0, "R4 alternate slow code dir1");
        t_chop(2'b10, 1'b0, 1'b0, "R6 mixed decay dir1");
        t_reverse_in_offtime();
        t_zero_level();
        t_level_pass();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule